// File: doc/BRIEF.md
# Two-Wire Slave Bit Engine with Clock-Low Timeout

This block is the bus-facing front end of a serial-presence-detect memory slave. It samples the two-wire clock and data lines with the system clock, detects START and STOP conditions, shifts incoming bytes in MSB first and compares the slave-address field of the select byte with three strap pins. It drives SDA only by pulling it low, for acknowledge bits and for the zero bits of read data.

The block does not decide whether a byte is acknowledged. For every byte, including the select byte, it samples a registered `ack_req_i` from the layer above when SCL falls after the eighth bit. That layer reports protection and page status by choosing ack or nack. During reads the upper layer supplies each byte on `tx_data_i`, and the block reports which byte it has taken with `tx_load_o`. The master's ack or nack after each read byte is also passed up. If SCL is held low for too long, a timer returns the engine to standby and releases SDA.

Top module: `smb_slave_fe`

## Requirements
- R1: START (SDA falls while SCL is high) pulses `start_o` and restarts select-byte reception from any state. STOP (SDA rises while SCL is high) pulses `stop_o` and returns the engine to standby. Both release SDA in the following cycle.
- R2: Bits are sampled on SCL rising edges, MSB first. After the eighth bit of a byte that follows the select byte in a write, `rx_valid_o` pulses once and `rx_data_o` holds the byte.
- R3: When bits 3:1 of the select byte equal `strap_i`, `sel_valid_o` pulses once. At that point `dev_type_o` holds bits 7:4 and `rw_o` holds bit 0 (1 = read).
- R4: When bits 3:1 of the select byte differ from `strap_i`, the select byte is not acknowledged. No strobe is issued and SDA stays released until the next START.
- R5: At the SCL fall after a byte's eighth bit, SDA is pulled low (ack) exactly when `ack_req_i` is 1, and it is released at the next SCL fall. After a nacked byte the engine ignores traffic until START or STOP.
- R6: After an acked read select, or after a master ack, `tx_load_o` pulses at an SCL fall and `tx_data_i` is sent MSB first. A bit value of 0 asserts `sda_oe_o` and a bit value of 1 releases it. A new bit is driven only after an SCL fall.
- R7: The master's ninth-bit response to a read byte is sampled on the SCL rise. It is reported as a `mack_valid_o` pulse, with `nack_o` = 1 for a nack. An ack starts the next byte. A nack releases SDA, and the engine ignores traffic until START or STOP.
- R8: If the synchronized SCL stays low for `TIMEOUT_CYC` consecutive clocks, `timeout_o` pulses, SDA is released and the engine returns to standby. Later traffic is ignored until a START.
- R9: SCL low periods shorter than `TIMEOUT_CYC` clocks leave a transfer unaffected, and `timeout_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Slave-address straps compared with select bits 3:1 |
| ack_req_i | input | 1 | Upper-layer ack decision (1 = ack) for the current byte |
| tx_data_i | input | 8 | Next read byte from the upper layer |
| sda_oe_o | output | 1 | Pull SDA low when 1; released when 0 |
| start_o | output | 1 | START detected pulse |
| stop_o | output | 1 | STOP detected pulse |
| timeout_o | output | 1 | SCL-low timeout pulse |
| sel_valid_o | output | 1 | Matching select byte received pulse |
| dev_type_o | output | 4 | Device-type nibble of the last matching select byte |
| rw_o | output | 1 | Direction bit of the last matching select byte |
| rx_valid_o | output | 1 | Write data byte received pulse |
| rx_data_o | output | 8 | Last received write data byte |
| tx_load_o | output | 1 | `tx_data_i` taken for transmission pulse |
| mack_valid_o | output | 1 | Master response to a read byte sampled pulse |
| nack_o | output | 1 | Master response value (1 = nack) |

## Verification
The hardest case to reach is a timeout that arrives while the slave itself is holding SDA low. The stimulus sends the eighth bit of a data byte and then parks SCL low. In that state the acknowledge pull-down is active, and the bench watches it appear, then holds SCL low past the timeout and checks that the pull-down is gone. It then clocks a full byte without a START to show that nothing is strobed and no ack is given. A second stretched transfer holds every low phase just under the limit, to show that the timer leaves a slow master alone.

// File: rtl/smb_fe_pkg.sv
package smb_fe_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned STRAP_W = 3;
  localparam int unsigned DEV_W   = 4;
  localparam int unsigned BCNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MNEXT,
    ST_WAIT
  } fe_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_q_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // conditions only count while SCL is high on both samples
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign scl_q_o    = scl_q;
endmodule

// File: rtl/smb_scl_timer.sv
module smb_scl_timer #(
  parameter int unsigned LIMIT = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM     = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1  = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (scl_s_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // single pulse per low period; counter saturates afterwards
  assign expire_o = ~scl_s_i & (cnt_q == LIM_M1);
endmodule

// File: rtl/smb_slave_fe.sv
module smb_slave_fe
  import smb_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 3_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               ack_req_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  output logic               sda_oe_o,
  output logic               start_o,
  output logic               stop_o,
  output logic               timeout_o,
  output logic               sel_valid_o,
  output logic [DEV_W-1:0]   dev_type_o,
  output logic               rw_o,
  output logic               rx_valid_o,
  output logic [BYTE_W-1:0]  rx_data_o,
  output logic               tx_load_o,
  output logic               mack_valid_o,
  output logic               nack_o
);
  logic [1:0] bus_s;
  logic       scl_s, sda_s, scl_q;
  logic       scl_rise, scl_fall, start_det, stop_det, tmo;

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  smb_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_q_o   (scl_q),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  smb_scl_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_s_i (scl_s),
    .expire_o(tmo)
  );

  fe_state_e          state_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic [BYTE_W-2:0]  rx_sh_q;
  logic [BYTE_W-1:0]  tx_sh_q;
  logic               first_q, acked_q, ack_ph_q, oe_q;
  logic               rw_q;
  logic [DEV_W-1:0]   dev_q;
  logic [BYTE_W-1:0]  rx_data_q;
  logic               sel_v_q, rx_v_q, tx_ld_q, mack_v_q, nack_q;
  logic [BYTE_W-1:0]  rx_byte;
  logic               last_bit;

  assign rx_byte  = {rx_sh_q, sda_s};
  assign last_bit = (bcnt_q == BCNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bcnt_q    <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      first_q   <= 1'b0;
      acked_q   <= 1'b0;
      ack_ph_q  <= 1'b0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      dev_q     <= '0;
      rx_data_q <= '0;
      sel_v_q   <= 1'b0;
      rx_v_q    <= 1'b0;
      tx_ld_q   <= 1'b0;
      mack_v_q  <= 1'b0;
      nack_q    <= 1'b0;
    end else begin
      sel_v_q  <= 1'b0;
      rx_v_q   <= 1'b0;
      tx_ld_q  <= 1'b0;
      mack_v_q <= 1'b0;
      if (tmo || stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_det) begin
        state_q  <= ST_RX;
        bcnt_q   <= '0;
        first_q  <= 1'b1;
        ack_ph_q <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: if (scl_rise) begin
            rx_sh_q <= rx_byte[BYTE_W-2:0];
            if (last_bit) begin
              bcnt_q   <= '0;
              ack_ph_q <= 1'b0;
              if (first_q) begin
                if (rx_byte[STRAP_W:1] == strap_i) begin
                  dev_q   <= rx_byte[BYTE_W-1 -: DEV_W];
                  rw_q    <= rx_byte[0];
                  sel_v_q <= 1'b1;
                  state_q <= ST_ACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else begin
                rx_data_q <= rx_byte;
                rx_v_q    <= 1'b1;
                state_q   <= ST_ACK;
              end
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_ph_q) begin
              ack_ph_q <= 1'b1;
              oe_q     <= ack_req_i;
              acked_q  <= ack_req_i;
            end else begin
              ack_ph_q <= 1'b0;
              first_q  <= 1'b0;
              bcnt_q   <= '0;
              if (!acked_q) begin
                oe_q    <= 1'b0;
                state_q <= ST_WAIT;
              end else if (rw_q) begin
                tx_sh_q <= tx_data_i;
                oe_q    <= ~tx_data_i[BYTE_W-1];
                tx_ld_q <= 1'b1;
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall) begin
              if (bcnt_q == BCNT_W'(BYTE_W)) begin
                oe_q    <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                // bit index 7-n equals ~n on three bits
                oe_q <= ~tx_sh_q[~bcnt_q[2:0]];
              end
            end
          end
          ST_MACK: if (scl_rise) begin
            mack_v_q <= 1'b1;
            nack_q   <= sda_s;
            state_q  <= sda_s ? ST_WAIT : ST_MNEXT;
          end
          ST_MNEXT: if (scl_fall) begin
            tx_sh_q <= tx_data_i;
            oe_q    <= ~tx_data_i[BYTE_W-1];
            tx_ld_q <= 1'b1;
            bcnt_q  <= '0;
            state_q <= ST_TX;
          end
          ST_IDLE, ST_WAIT: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o     = oe_q;
  assign start_o      = start_det;
  assign stop_o       = stop_det;
  assign timeout_o    = tmo;
  assign sel_valid_o  = sel_v_q;
  assign dev_type_o   = dev_q;
  assign rw_o         = rw_q;
  assign rx_valid_o   = rx_v_q;
  assign rx_data_o    = rx_data_q;
  assign tx_load_o    = tx_ld_q;
  assign mack_valid_o = mack_v_q;
  assign nack_o       = nack_q;
endmodule

// File: rtl/smb_slave_fe_chk.sv
module smb_slave_fe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic start_o,
  input logic stop_o,
  input logic timeout_o,
  input logic scl_q,
  input logic sel_valid_o,
  input logic rx_valid_o,
  input logic tx_load_o,
  input logic mack_valid_o
);
  // R1
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !sda_oe_o);

  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !sda_oe_o);

  // R8
  timeout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !sda_oe_o);

  // R6
  oe_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_q);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_valid_o, rx_valid_o, tx_load_o, mack_valid_o}));
endmodule

bind smb_slave_fe smb_slave_fe_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_oe_o    (sda_oe_o),
  .start_o     (start_o),
  .stop_o      (stop_o),
  .timeout_o   (timeout_o),
  .scl_q       (scl_q),
  .sel_valid_o (sel_valid_o),
  .rx_valid_o  (rx_valid_o),
  .tx_load_o   (tx_load_o),
  .mack_valid_o(mack_valid_o)
);

// File: tb/smb_slave_fe_tb_top.sv
module smb_slave_fe_tb_top;
  localparam int TMO = 200;
  localparam int H   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       ack_req = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] tx_data;
  logic       sda_oe, start_p, stop_p, tmo_p, sel_v, rw, rx_v, tx_ld, mack_v, nack;
  logic [3:0] dev;
  logic [7:0] rx_d;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] tx_tab [4] = '{8'hA5, 8'h3C, 8'h0F, 8'hE1};
  int tx_idx = 0;
  assign tx_data = tx_tab[tx_idx[1:0]];
  always @(posedge clk) if (tx_ld) tx_idx <= tx_idx + 1;

  smb_slave_fe #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .ack_req_i(ack_req), .tx_data_i(tx_data),
    .sda_oe_o(sda_oe), .start_o(start_p), .stop_o(stop_p), .timeout_o(tmo_p),
    .sel_valid_o(sel_v), .dev_type_o(dev), .rw_o(rw), .rx_valid_o(rx_v),
    .rx_data_o(rx_d), .tx_load_o(tx_ld), .mack_valid_o(mack_v), .nack_o(nack)
  );

  int tests = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_tmo = 0;
  logic [9:0] exp_q [$];
  string      req_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind 0 = select, 1 = write byte, 2 = master response
  task automatic push(input logic [1:0] k, input logic [7:0] d, input string req);
    exp_q.push_back({k, d});
    req_q.push_back(req);
  endtask

  task automatic mon_item(input logic [9:0] got);
    logic [9:0] e;
    string r;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4", "unexpected strobe", int'(got), 0);
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(got == e, r, "scoreboard item", int'(got), int'(e));
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (start_p) n_start++;
    if (stop_p)  n_stop++;
    if (tmo_p)   n_tmo++;
    if (sel_v)   mon_item({2'd0, dev, 3'b000, rw});
    if (rx_v)    mon_item({2'd1, rx_d});
    if (mack_v)  mon_item({2'd2, 7'd0, nack});
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic clk_bit(input logic b, input int low_cyc, output logic s);
    wait_n(2);
    sda_m = b;
    wait_n(low_cyc - 2);
    scl_m = 1'b1;
    wait_n(H / 2);
    s = sda_line;
    wait_n(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, input int low_cyc, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], low_cyc, s);
    clk_bit(1'b1, low_cyc, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, H, s);
      b[i] = s;
    end
    clk_bit(~m_ack, H, s);
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_tb();
  end

  initial begin
    logic a, s;
    logic [7:0] b;
    int st0, sp0, tm0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R1: standby after reset
    chk(!sda_oe && !sel_v && !rx_v && !tx_ld && !mack_v, "R1", "reset outputs",
        {sda_oe, sel_v, rx_v, tx_ld, mack_v}, 0);

    // R3 R5 R2: matching write select, then data bytes
    st0 = n_start;
    bus_start();
    chk(n_start == st0 + 1, "R1", "start pulse", n_start - st0, 1);
    push(2'd0, 8'hA0, "R3");
    wr_byte(8'hAA, H, a);
    chk(a, "R5", "select ack", a, 1);
    push(2'd1, 8'h5C, "R2");
    wr_byte(8'h5C, H, a);
    chk(a, "R5", "data ack", a, 1);
    push(2'd1, 8'h81, "R2");
    wr_byte(8'h81, H, a);
    sp0 = n_stop;
    bus_stop();
    chk(n_stop == sp0 + 1, "R1", "stop pulse", n_stop - sp0, 1);
    chk(!sda_oe, "R1", "released after stop", sda_oe, 0);

    // R5: upper layer refuses a data byte
    bus_start();
    push(2'd0, 8'hA0, "R3");
    wr_byte(8'hAA, H, a);
    ack_req = 1'b0;
    push(2'd1, 8'h33, "R2");
    wr_byte(8'h33, H, a);
    chk(!a, "R5", "nack when ack_req low", a, 0);
    ack_req = 1'b1;
    wr_byte(8'h77, H, a);
    chk(!a, "R5", "ignored after nack", a, 0);
    bus_stop();

    // R4: address mismatch
    bus_start();
    wr_byte(8'hA6, H, a);
    chk(!a, "R4", "mismatch not acked", a, 0);
    wr_byte(8'h12, H, a);
    chk(!a, "R4", "traffic ignored", a, 0);
    bus_stop();

    // R6 R7: sequential read
    bus_start();
    push(2'd0, 8'hA1, "R3");
    wr_byte(8'hAB, H, a);
    chk(a, "R5", "read select ack", a, 1);
    push(2'd2, 8'h00, "R7");
    rd_byte(1'b1, b);
    chk(b == 8'hA5, "R6", "read byte 0", b, 8'hA5);
    push(2'd2, 8'h00, "R7");
    rd_byte(1'b1, b);
    chk(b == 8'h3C, "R6", "read byte 1", b, 8'h3C);
    push(2'd2, 8'h01, "R7");
    rd_byte(1'b0, b);
    chk(b == 8'h0F, "R6", "read byte 2", b, 8'h0F);
    rd_byte(1'b0, b);
    chk(b == 8'hFF, "R7", "released after master nack", b, 8'hFF);
    chk(tx_idx == 3, "R6", "tx loads", tx_idx, 3);
    bus_stop();

    // R1: repeated start aborts a partial byte
    st0 = n_start;
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b0, H, s);
    bus_start();
    chk(n_start == st0 + 2, "R1", "two starts", n_start - st0, 2);
    push(2'd0, 8'hA0, "R1");
    wr_byte(8'hAA, H, a);
    chk(a, "R1", "select after restart", a, 1);
    push(2'd1, 8'h66, "R2");
    wr_byte(8'h66, H, a);
    bus_stop();

    // R9: long but legal low phases
    tm0 = n_tmo;
    bus_start();
    push(2'd0, 8'hA0, "R9");
    wr_byte(8'hAA, H, a);
    push(2'd1, 8'hC3, "R9");
    wr_byte(8'hC3, TMO - 40, a);
    chk(a, "R9", "slow byte acked", a, 1);
    chk(n_tmo == tm0, "R9", "no timeout", n_tmo - tm0, 0);
    bus_stop();

    // R8: timeout while the slave holds the ack low
    bus_start();
    push(2'd0, 8'hA0, "R8");
    wr_byte(8'hAA, H, a);
    push(2'd1, 8'h5A, "R8");
    for (int i = 7; i >= 0; i--) clk_bit(b[0] ^ b[0] ^ ((8'h5A >> i) & 1), H, s);
    wait_n(20);
    chk(sda_oe, "R5", "ack driven before timeout", sda_oe, 1);
    wait_n(TMO + 50);
    chk(n_tmo == tm0 + 1, "R8", "timeout pulse", n_tmo - tm0, 1);
    chk(!sda_oe, "R8", "released on timeout", sda_oe, 0);
    wr_byte(8'h99, H, a);
    chk(!a, "R8", "ignored after timeout", a, 0);
    bus_stop();

    wait_n(20);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
    finish_tb();
  end
endmodule